// File: doc/BRIEF.md
# Prioritized Interrupt and Fault Controller

This block gathers sixteen interrupt levels and a sixteen-bit fault register for a processor core. Falling edges on user and IO-level interrupt lines, and on the power-fail line, are latched into a pending register. The fault register collects bus-error, protect, parity and system-fault conditions. Where each fault lands depends on the kind of bus cycle in progress and on whether this processor owns the bus.

Any set fault bit is reflected as the machine-error level in the pending view. The controller offers the highest-numbered eligible level on `irq_level` and raises `irq_req` when that level is allowed through. A level is eligible when it is pending and its mask bit is set. Machine error and power fail are always eligible. The global enable gates every level except power fail.

Software reaches the pending, mask and fault registers through a single-cycle register port. The port supports load, bit-set and bit-clear operations, and a combinational read.

Top module: `irqf_ctrl`

## Requirements
- R1: While `rst_n` is low, the pending, mask and fault registers are all zero and `irq_req` is low. This also holds when reset is applied in the middle of operation.
- R2: A falling edge on `usr_irq_n[i]` sets pending bit 2+i. A line that is held low does not set the bit again after software clears it.
- R3: A falling edge on `io_irq_n[j]` sets pending bit 8+j.
- R4: Mask bit k set to 1 enables pending level k, for k from 0 to 13. Levels 14 and 15 ignore the mask, and mask bits 14 and 15 always read zero.
- R5: `irq_level` gives the highest-numbered eligible level. It reads 0 when no level is eligible.
- R6: With `glob_en` low, `irq_req` is raised only when pending bit 15 is set.
- R7: A falling edge on `pwr_fail_n` sets pending bit 15. That level is never masked.
- R8: Pending bit 14 reads as the OR of all fault bits. Software writes to pending bit 14 have no effect.
- R9: `bus_err_n` low sets fault bit 10 when `cyc_is_io`=1, and fault bit 7 when `cyc_is_io`=0.
- R10: `mprot_n` low sets fault bit 15 when `bus_owned`=1, and fault bit 14 when `bus_owned`=0.
- R11: `mpar` high sets fault bit 13. A rising edge on `sys_fault` sets fault bit 8; holding `sys_fault` high does not set the bit again after software clears it.
- R12: While bus-error, protect or parity is still asserted, a software clear of the fault bit it drives has no effect.
- R13: The register port uses `reg_sel` 0 for pending, 1 for mask, 2 for fault, and 3 for nothing (reads zero). `reg_op` 0 loads, 1 sets bits and 2 clears bits; an operation takes effect at the clock edge where `reg_we` is high. Fault bits other than 15, 14, 13, 10, 8 and 7 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| glob_en | input | 1 | Global interrupt enable |
| usr_irq_n | input | 6 | User interrupts, falling-edge active |
| io_irq_n | input | 2 | IO-level interrupts, falling-edge active |
| pwr_fail_n | input | 1 | Power fail, falling-edge active |
| bus_err_n | input | 1 | Bus timeout or error, active low level |
| cyc_is_io | input | 1 | 1 = current bus cycle is IO, 0 = memory |
| bus_owned | input | 1 | 1 = this processor owns the bus |
| mprot_n | input | 1 | Memory protect fault, active low level |
| mpar | input | 1 | Memory parity fault, active high level |
| sys_fault | input | 1 | System fault, rising-edge active |
| reg_we | input | 1 | Register operation strobe |
| reg_sel | input | 2 | Register select |
| reg_op | input | 2 | Operation: load, set or clear |
| reg_wdata | input | 16 | Operand for the operation |
| reg_rdata | output | 16 | Read value of the selected register |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 4 | Winning level number |

## Verification
Single edges on one user line and then on one IO line show that each line lands in its own pending bit. They also show that the higher level wins. A line held low and then cleared by software separates edge capture from level capture. The same pair of patterns, applied to `sys_fault` and to `mpar`, separates the edge-set fault from the sticky level faults. Each fault input is pulsed under both values of its steering input (`cyc_is_io` or `bus_owned`), which exposes swapped bit placement. Runs with the mask cleared and `glob_en` low separate the always-on levels from the gated ones.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int NLEV  = 16;
  localparam int LVL_W = $clog2(NLEV);

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_NONE = 2'd3
  } reg_op_e;

  typedef enum logic [1:0] {
    SEL_PEND  = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_FAULT = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // pending levels with fixed meaning
  localparam int PF_BIT = 15;
  localparam int ME_BIT = 14;

  // fault register bit positions
  localparam int FB_CPU_PROT = 15;
  localparam int FB_DMA_PROT = 14;
  localparam int FB_PARITY   = 13;
  localparam int FB_BUS_IO   = 10;
  localparam int FB_SYS      = 8;
  localparam int FB_BUS_MEM  = 7;

  localparam logic [NLEV-1:0] FAULT_IMPL = NLEV'((1 << FB_CPU_PROT) | (1 << FB_DMA_PROT) |
                                                 (1 << FB_PARITY) | (1 << FB_BUS_IO) |
                                                 (1 << FB_SYS) | (1 << FB_BUS_MEM));
  localparam logic [NLEV-1:0] UNMASKABLE = NLEV'((1 << PF_BIT) | (1 << ME_BIT));
  localparam logic [NLEV-1:0] PEND_IMPL  = ~NLEV'(1 << ME_BIT);
  localparam logic [NLEV-1:0] MASK_IMPL  = ~UNMASKABLE;
endpackage

// File: rtl/irqf_edge.sv
module irqf_edge #(
  parameter int W       = 1,
  parameter bit ACT_LOW = 1'b1
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] sig,
  output logic [W-1:0] hit
);
  localparam logic [W-1:0] IDLE = {W{ACT_LOW}};

  logic [W-1:0] prev_q, prev_d;

  always_comb prev_d = sig;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) prev_q <= IDLE;
    else         prev_q <= prev_d;
  end

  generate
    if (ACT_LOW) begin : g_fall
      assign hit = prev_q & ~sig;
    end else begin : g_rise
      assign hit = ~prev_q & sig;
    end
  endgenerate
endmodule

// File: rtl/irqf_swreg.sv
module irqf_swreg
  import irqf_pkg::*;
#(
  parameter int           W    = 16,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         we,
  input  logic [1:0]   op,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  logic [W-1:0] sw_d, nxt;
  logic         en;

  always_comb begin
    sw_d = q;
    if (we) begin
      unique case (reg_op_e'(op))
        OP_LOAD: sw_d = wdata;
        OP_SET:  sw_d = q | wdata;
        OP_CLR:  sw_d = q & ~wdata;
        default: sw_d = q;
      endcase
    end
    // hardware sets win over a software clear in the same cycle
    nxt = (sw_d | hw_set) & IMPL;
    en  = we | (|hw_set);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  q <= '0;
    else if (en)  q <= nxt;
  end
endmodule

// File: rtl/irqf_fault_steer.sv
module irqf_fault_steer
  import irqf_pkg::*;
(
  input  logic            bus_err_n,
  input  logic            cyc_is_io,
  input  logic            bus_owned,
  input  logic            mprot_n,
  input  logic            mpar,
  input  logic            sys_rise,
  output logic [NLEV-1:0] set_vec
);
  always_comb begin
    set_vec = '0;
    set_vec[FB_BUS_IO]   = ~bus_err_n & cyc_is_io;
    set_vec[FB_BUS_MEM]  = ~bus_err_n & ~cyc_is_io;
    set_vec[FB_CPU_PROT] = ~mprot_n & bus_owned;
    set_vec[FB_DMA_PROT] = ~mprot_n & ~bus_owned;
    set_vec[FB_PARITY]   = mpar;
    set_vec[FB_SYS]      = sys_rise;
  end
endmodule

// File: rtl/irqf_prio.sv
module irqf_prio #(
  parameter int W  = 16,
  parameter int LW = $clog2(W)
) (
  input  logic [W-1:0]  cand,
  output logic          any,
  output logic [LW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (cand[i]) begin
        any = 1'b1;
        idx = LW'(i);
      end
    end
  end
endmodule

// File: rtl/irqf_ctrl.sv
module irqf_ctrl
  import irqf_pkg::*;
#(
  parameter int N_USR    = 6,
  parameter int N_IO     = 2,
  parameter int USR_BASE = 2,
  parameter int IO_BASE  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glob_en,
  input  logic [N_USR-1:0] usr_irq_n,
  input  logic [N_IO-1:0]  io_irq_n,
  input  logic             pwr_fail_n,
  input  logic             bus_err_n,
  input  logic             cyc_is_io,
  input  logic             bus_owned,
  input  logic             mprot_n,
  input  logic             mpar,
  input  logic             sys_fault,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [1:0]       reg_op,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  output logic             irq_req,
  output logic [3:0]       irq_level
);
  localparam int N_EDGE = N_USR + N_IO + 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  // edge capture
  logic [N_EDGE-1:0] fall_hit;
  logic [0:0]        rise_hit;

  irqf_edge #(.W(N_EDGE), .ACT_LOW(1'b1)) u_fall (
    .clk(clk), .rst_ni(rst_q),
    .sig({pwr_fail_n, io_irq_n, usr_irq_n}), .hit(fall_hit));

  irqf_edge #(.W(1), .ACT_LOW(1'b0)) u_rise (
    .clk(clk), .rst_ni(rst_q), .sig(sys_fault), .hit(rise_hit));

  logic [NLEV-1:0] pend_hw, fault_hw;
  always_comb begin
    pend_hw = '0;
    pend_hw[USR_BASE +: N_USR] = fall_hit[N_USR-1:0];
    pend_hw[IO_BASE +: N_IO]   = fall_hit[N_USR +: N_IO];
    pend_hw[PF_BIT]            = fall_hit[N_EDGE-1];
  end

  irqf_fault_steer u_steer (
    .bus_err_n(bus_err_n), .cyc_is_io(cyc_is_io), .bus_owned(bus_owned),
    .mprot_n(mprot_n), .mpar(mpar), .sys_rise(rise_hit[0]), .set_vec(fault_hw));

  // registers
  logic            pend_we, mask_we, fault_we;
  logic [NLEV-1:0] pend_q, mask_q, fault_q;

  always_comb begin
    pend_we  = reg_we && (reg_sel_e'(reg_sel) == SEL_PEND);
    mask_we  = reg_we && (reg_sel_e'(reg_sel) == SEL_MASK);
    fault_we = reg_we && (reg_sel_e'(reg_sel) == SEL_FAULT);
  end

  irqf_swreg #(.W(NLEV), .IMPL(PEND_IMPL)) u_pend (
    .clk(clk), .rst_ni(rst_q), .we(pend_we), .op(reg_op),
    .wdata(reg_wdata), .hw_set(pend_hw), .q(pend_q));

  irqf_swreg #(.W(NLEV), .IMPL(MASK_IMPL)) u_mask (
    .clk(clk), .rst_ni(rst_q), .we(mask_we), .op(reg_op),
    .wdata(reg_wdata), .hw_set('0), .q(mask_q));

  irqf_swreg #(.W(NLEV), .IMPL(FAULT_IMPL)) u_fault (
    .clk(clk), .rst_ni(rst_q), .we(fault_we), .op(reg_op),
    .wdata(reg_wdata), .hw_set(fault_hw), .q(fault_q));

  // eligibility and priority
  logic [NLEV-1:0] pend_view, eligible;
  always_comb begin
    pend_view         = pend_q;
    pend_view[ME_BIT] = |fault_q;
    eligible          = pend_view & (mask_q | UNMASKABLE);
    if (!glob_en) eligible = eligible & NLEV'(1 << PF_BIT);
  end

  irqf_prio #(.W(NLEV), .LW(LVL_W)) u_prio (
    .cand(eligible), .any(irq_req), .idx(irq_level));

  always_comb begin
    unique case (reg_sel_e'(reg_sel))
      SEL_PEND:  reg_rdata = pend_view;
      SEL_MASK:  reg_rdata = mask_q;
      SEL_FAULT: reg_rdata = fault_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqf_checker.sv
module irqf_checker (
  input logic        clk,
  input logic        rst_ni,
  input logic        glob_en,
  input logic [5:0]  usr_irq_n,
  input logic        bus_err_n,
  input logic        cyc_is_io,
  input logic        bus_owned,
  input logic        mprot_n,
  input logic        mpar,
  input logic [15:0] pend_q,
  input logic [15:0] fault_q,
  input logic        irq_req,
  input logic [3:0]  irq_level
);
  p_pf_wins_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    pend_q[15] |-> (irq_req && irq_level == 4'd15));

  p_gated_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!glob_en && !pend_q[15]) |-> !irq_req);

  p_machine_err_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    ((|fault_q) && glob_en && !pend_q[15]) |-> (irq_req && irq_level == 4'd14));

  p_usr_edge_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(usr_irq_n[0]) |=> pend_q[2]);

  p_bus_io_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (!bus_err_n && cyc_is_io) |=> fault_q[10]);

  p_bus_mem_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (!bus_err_n && !cyc_is_io) |=> fault_q[7]);

  p_prot_owner_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (!mprot_n && bus_owned) |=> fault_q[15]);

  p_parity_hold_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    mpar |=> fault_q[13]);
endmodule

bind irqf_ctrl irqf_checker u_chk (
  .clk(clk), .rst_ni(rst_q), .glob_en(glob_en), .usr_irq_n(usr_irq_n),
  .bus_err_n(bus_err_n), .cyc_is_io(cyc_is_io), .bus_owned(bus_owned),
  .mprot_n(mprot_n), .mpar(mpar), .pend_q(pend_q), .fault_q(fault_q),
  .irq_req(irq_req), .irq_level(irq_level));

// File: tb/irqf_ctrl_test.sv
`timescale 1ns/1ps
module irqf_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        glob_en;
  logic [5:0]  usr_irq_n;
  logic [1:0]  io_irq_n;
  logic        pwr_fail_n, bus_err_n, cyc_is_io, bus_owned, mprot_n, mpar, sys_fault;
  logic        reg_we;
  logic [1:0]  reg_sel, reg_op;
  logic [15:0] reg_wdata, reg_rdata;
  logic        irq_req;
  logic [3:0]  irq_level;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    bit          is_irq;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  irqf_ctrl uut (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .usr_irq_n(usr_irq_n),
    .io_irq_n(io_irq_n), .pwr_fail_n(pwr_fail_n), .bus_err_n(bus_err_n),
    .cyc_is_io(cyc_is_io), .bus_owned(bus_owned), .mprot_n(mprot_n),
    .mpar(mpar), .sys_fault(sys_fault), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_op(reg_op), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_level(irq_level));

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it  = sb.pop_front();
        act = it.is_irq ? {11'd0, irq_req, irq_level} : reg_rdata;
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic chk_rd(input logic [1:0] sel, input logic [15:0] exp, input string tag);
    @(negedge clk);
    reg_sel = sel;
    sb.push_back('{is_irq: 1'b0, exp: exp, tag: tag});
  endtask

  task automatic chk_irq(input logic req, input logic [3:0] lvl, input string tag);
    @(negedge clk);
    sb.push_back('{is_irq: 1'b1, exp: {11'd0, req, lvl}, tag: tag});
  endtask

  task automatic wr(input logic [1:0] sel, input logic [1:0] op, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_op = op; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_op = 2'd3;
  endtask

  task automatic pulse_usr(input int i);
    @(negedge clk); usr_irq_n[i] = 1'b0;
    @(negedge clk); usr_irq_n[i] = 1'b1;
  endtask

  task automatic pulse_io(input int j);
    @(negedge clk); io_irq_n[j] = 1'b0;
    @(negedge clk); io_irq_n[j] = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  localparam logic [1:0] PEND = 2'd0, MASK = 2'd1, FLT = 2'd2, NSEL = 2'd3;
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, CL = 2'd2;

  initial begin
    rst_n = 1'b0; glob_en = 1'b0; usr_irq_n = '1; io_irq_n = '1; pwr_fail_n = 1'b1;
    bus_err_n = 1'b1; cyc_is_io = 1'b0; bus_owned = 1'b1; mprot_n = 1'b1;
    mpar = 1'b0; sys_fault = 1'b0; reg_we = 1'b0; reg_sel = 2'd0; reg_op = 2'd3;
    reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk_rd(PEND, 16'h0000, "R1 pending after reset");
    chk_rd(MASK, 16'h0000, "R1 mask after reset");
    chk_rd(FLT,  16'h0000, "R1 fault after reset");
    chk_irq(1'b0, 4'd0, "R1 no request after reset");
    chk_rd(NSEL, 16'h0000, "R13 unused select reads zero");

    glob_en = 1'b1;
    wr(MASK, LD, 16'hFFFF);
    chk_rd(MASK, 16'h3FFF, "R4 mask bits 14,15 read zero");

    pulse_usr(3);
    chk_rd(PEND, 16'h0020, "R2 user line 3 sets bit 5");
    chk_irq(1'b1, 4'd5, "R5 single level");

    pulse_io(1);
    chk_rd(PEND, 16'h0220, "R3 io line 1 sets bit 9");
    chk_irq(1'b1, 4'd9, "R5 higher level wins");

    wr(MASK, CL, 16'h0200);
    chk_rd(MASK, 16'h3DFF, "R13 mask clear op");
    chk_irq(1'b1, 4'd5, "R4 masked level skipped");

    @(negedge clk); glob_en = 1'b0;
    chk_irq(1'b0, 4'd0, "R6 global enable off");

    @(negedge clk); pwr_fail_n = 1'b0;
    @(negedge clk); pwr_fail_n = 1'b1;
    chk_irq(1'b1, 4'd15, "R7 power fail bypasses enable");
    chk_rd(PEND, 16'h8220, "R7 power fail sets bit 15");

    wr(PEND, CL, 16'h8220);
    chk_rd(PEND, 16'h0000, "R13 pending clear op");
    chk_irq(1'b0, 4'd0, "R6 nothing left");

    wr(MASK, LD, 16'h0000);
    @(negedge clk); glob_en = 1'b1;

    @(negedge clk); usr_irq_n[0] = 1'b0;
    @(negedge clk);
    chk_rd(PEND, 16'h0004, "R2 user line 0 sets bit 2");
    wr(PEND, CL, 16'h0004);
    chk_rd(PEND, 16'h0000, "R2 held-low line does not re-set");
    @(negedge clk); usr_irq_n[0] = 1'b1;

    @(negedge clk); cyc_is_io = 1'b1; bus_err_n = 1'b0;
    @(negedge clk); bus_err_n = 1'b1;
    chk_rd(FLT, 16'h0400, "R9 bus error in io cycle");
    chk_rd(PEND, 16'h4000, "R8 machine error pending");
    chk_irq(1'b1, 4'd14, "R4 machine error ignores mask");
    wr(PEND, CL, 16'h4000);
    chk_rd(PEND, 16'h4000, "R8 software cannot clear bit 14");
    wr(FLT, CL, 16'hFFFF);
    chk_rd(PEND, 16'h0000, "R8 bit 14 follows fault register");
    chk_irq(1'b0, 4'd0, "R8 request drops");

    @(negedge clk); cyc_is_io = 1'b0; bus_err_n = 1'b0;
    @(negedge clk); bus_err_n = 1'b1;
    chk_rd(FLT, 16'h0080, "R9 bus error in memory cycle");
    wr(FLT, CL, 16'hFFFF);

    @(negedge clk); mpar = 1'b1;
    @(negedge clk);
    chk_rd(FLT, 16'h2000, "R11 parity sets bit 13");
    wr(FLT, CL, 16'h2000);
    chk_rd(FLT, 16'h2000, "R12 clear ignored while parity held");
    @(negedge clk); mpar = 1'b0;
    wr(FLT, CL, 16'h2000);
    chk_rd(FLT, 16'h0000, "R12 clear works after release");

    @(negedge clk); bus_owned = 1'b1; mprot_n = 1'b0;
    @(negedge clk);
    wr(FLT, CL, 16'h8000);
    chk_rd(FLT, 16'h8000, "R10 owner protect bit 15, R12 held");
    @(negedge clk); mprot_n = 1'b1;
    wr(FLT, CL, 16'hFFFF);
    @(negedge clk); bus_owned = 1'b0; mprot_n = 1'b0;
    @(negedge clk); mprot_n = 1'b1;
    chk_rd(FLT, 16'h4000, "R10 non-owner protect bit 14");
    wr(FLT, CL, 16'hFFFF);

    @(negedge clk); sys_fault = 1'b1;
    @(negedge clk);
    chk_rd(FLT, 16'h0100, "R11 system fault edge sets bit 8");
    wr(FLT, CL, 16'h0100);
    chk_rd(FLT, 16'h0000, "R11 held system fault does not re-set");
    @(negedge clk); sys_fault = 1'b0;

    wr(FLT, LD, 16'hFFFF);
    chk_rd(FLT, 16'hE580, "R13 unused fault bits read zero");
    wr(FLT, CL, 16'hFFFF);

    wr(PEND, ST, 16'h0009);
    wr(MASK, LD, 16'h0008);
    chk_rd(PEND, 16'h0009, "R13 pending set op");
    chk_irq(1'b1, 4'd3, "R5 only unmasked level 3 chosen");

    wr(FLT, LD, 16'h8000);
    do_reset();
    chk_rd(PEND, 16'h0000, "R1 mid-run reset pending");
    chk_rd(MASK, 16'h0000, "R1 mid-run reset mask");
    chk_rd(FLT,  16'h0000, "R1 mid-run reset fault");
    chk_irq(1'b0, 4'd0, "R1 mid-run reset request");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule